// File: doc/BRIEF.md
# Framed Six-Channel Serial Transmitter

This block takes one set of three-phase measurements from a converter core and sends it out over a three-wire port. The three wires are a gated serial clock, a one-period frame strobe and a data line. The core presents six 16-bit words on a flat parallel bus and pulses a sample-ready strobe. The block copies the words into a holding register and raises the frame strobe for one serial-clock period. It then runs the serial clock for exactly 96 periods while the data line carries every word, most-significant bit first.

The serial clock comes from dividing the system clock by an even parameter. Each serial period starts with a low half and ends with a high half. The data line changes only as the serial clock falls, so a receiver samples it on the rising edge. Between frames the serial clock, the data line and the frame strobe all rest low.

A sample strobe that arrives while a frame is in flight is dropped, and it sets a sticky overrun flag. A synchronous active-low reset returns every register to its default and cancels a frame that is in progress.

Top module: `frame_serializer`

## Requirements
- R1: While `rst_n` is low at a clock edge, every register returns to its default. After that edge, `ser_clk`, `frame_out`, `ser_data`, `busy` and `overrun` are all 0, even when the reset lands in the middle of a frame.
- R2: A `smp_valid` that is sampled while `busy` is 0 raises `frame_out` for exactly CLK_DIV system cycles, which is one serial period. It rises on the first of those cycles, the one that begins at the accepting edge.
- R3: `ser_clk` is 0 in every cycle where `frame_out` is 1, and in every cycle where `busy` is 0.
- R4: Once `frame_out` falls, `ser_clk` runs for exactly 96 periods of CLK_DIV cycles each. Each period is low for the first CLK_DIV/2 cycles and high for the last CLK_DIV/2 cycles, and the clock then stays low.
- R5: The 96 bits are six 16-bit words, each sent MSB first. Words go out in ascending bus index, where word k sits in `smp_data[16k+15:16k]`. Index 0 is phase-1 voltage, 1 is phase-1 current, 2 and 3 are phase-2 voltage and current, and 4 and 5 are phase-3 voltage and current.
- R6: `ser_data` holds each bit for a whole serial period and changes only in the cycle where `ser_clk` falls, or at the start of the first bit. Outside the 96-bit window it is 0.
- R7: The words sent are the ones on `smp_data` at the accepting edge. Later changes of `smp_data` do not alter the frame.
- R8: A `smp_valid` sampled while `busy` is 1 neither restarts nor alters the current frame and starts no later frame. From the next cycle on it sets `overrun` to 1, and only reset clears the flag.
- R9: `busy` is 1 from the frame-strobe cycle through the last cycle of bit 96 and 0 otherwise. A strobe in the first cycle with `busy` at 0 is accepted, so frames can run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Sample-ready strobe from the converter core |
| smp_data | input | NUM_WORDS*WORD_W (96) | Six words, word k at bits [16k+15:16k] |
| ser_clk | output | 1 | Gated serial clock, low when idle |
| frame_out | output | 1 | Frame strobe, one serial period wide |
| ser_data | output | 1 | Serial data, MSB first, changes on the falling serial clock |
| busy | output | 1 | Frame in progress |
| overrun | output | 1 | Sticky flag: a strobe arrived while busy |

## Verification
All timing is counted from the clock edge that accepts `smp_valid`, which is cycle k = 0. `frame_out` is due high in cycles 0 to CLK_DIV-1. Bit b occupies cycles CLK_DIV·(b+1) to CLK_DIV·(b+2)-1, with `ser_clk` high in the second half of that span, and the port goes idle at cycle 97·CLK_DIV. `overrun` is due one cycle after the edge that samples a strobe while busy. The bench drives on falling edges and samples every output at each falling edge. It compares the outputs with a table computed from k, so every result is checked in the cycle it becomes due. It also rebuilds the words from the rising serial-clock edges and compares them with the words that were captured.

// File: rtl/fs_pkg.sv
// Package: shared types for the framed serial transmitter.
// Assumes: nothing beyond IEEE 1800-2017.
package fs_pkg;

    // Sequencer states: idle, frame-strobe period, bit shifting.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FRAME = 2'd1,
        ST_SHIFT = 2'd2
    } fs_state_e;

endpackage

// File: rtl/fs_tick_gen.sv
// Module: fs_tick_gen
// Divides the system clock into serial periods of DIV cycles. It reports the
// last cycle of each period and whether the current cycle is in the high half.
// Assumes: DIV is even and at least 2. The counter runs only while run_i is high
// and restarts from zero whenever run_i rises.
module fs_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic period_end_o,
    output logic high_phase_o
);

    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);
    localparam logic [CW-1:0] HALF = CW'(DIV / 2);

    logic [CW-1:0] cnt_q;

    // Cycle counter within one serial period, held at zero while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign period_end_o = run_i && (cnt_q == LAST);
    assign high_phase_o = (cnt_q >= HALF);

    AST_TICK_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R4
    AST_TICK_FRESH_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_i) |-> (cnt_q == '0)); // R2

endmodule

// File: rtl/fs_sample_hold.sv
// Module: fs_sample_hold
// Copies the parallel sample bus into a holding register when a strobe comes
// while the transmitter is free. Flags strobes that come while it is busy.
// Assumes: busy_i comes from the sequencer register, so accept_o has no loop.
module fs_sample_hold #(
    parameter int BUS_W = 96
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid_i,
    input  logic [BUS_W-1:0] smp_data_i,
    input  logic             busy_i,
    output logic             accept_o,
    output logic [BUS_W-1:0] held_o,
    output logic             overrun_o
);

    logic [BUS_W-1:0] held_q;
    logic             ovr_q;

    assign accept_o = smp_valid_i && !busy_i;

    // Holding register, written only by an accepted strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (accept_o) begin
            held_q <= smp_data_i;
        end
    end

    // Sticky overrun flag, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
        end else if (smp_valid_i && busy_i) begin
            ovr_q <= 1'b1;
        end
    end

    assign held_o    = held_q;
    assign overrun_o = ovr_q;

    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> $stable(held_q)); // R7
    AST_OVR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid_i && busy_i) |=> ovr_q); // R8
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_q |=> ovr_q); // R8

endmodule

// File: rtl/fs_shift_engine.sv
// Module: fs_shift_engine
// Sequencer and shift register. After a start it spends one serial period in
// the frame state, then loads the held words into the shift register with word
// 0 at the top and shifts out every bit, one per serial period.
// Assumes: held_i stays stable while busy_o is high. period_end_i and
// high_phase_i come from a tick generator that runs while busy_o is high.
module fs_shift_engine #(
    parameter int WORD_W    = 16,
    parameter int NUM_WORDS = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_i,
    input  logic                          period_end_i,
    input  logic                          high_phase_i,
    input  logic [NUM_WORDS*WORD_W-1:0]   held_i,
    output logic                          ser_clk_o,
    output logic                          frame_o,
    output logic                          ser_data_o,
    output logic                          busy_o
);
    import fs_pkg::*;

    localparam int TOTAL = NUM_WORDS * WORD_W;
    localparam int BW    = $clog2(TOTAL);
    localparam logic [BW-1:0] LAST_BIT = BW'(TOTAL - 1);

    fs_state_e      state_q;
    logic [TOTAL-1:0] shreg_q;
    logic [TOTAL-1:0] load_vec;
    logic [BW-1:0]    bit_q;

    // Word 0 goes to the top of the shift register so that it leaves first.
    for (genvar k = 0; k < NUM_WORDS; k++) begin : g_order
        assign load_vec[TOTAL-1-k*WORD_W -: WORD_W] = held_i[k*WORD_W +: WORD_W];
    end

    // Frame sequencer, shift register and bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            shreg_q <= '0;
            bit_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_FRAME;
                    end
                end
                ST_FRAME: begin
                    if (period_end_i) begin
                        state_q <= ST_SHIFT;
                        shreg_q <= load_vec;
                        bit_q   <= '0;
                    end
                end
                ST_SHIFT: begin
                    if (period_end_i) begin
                        shreg_q <= {shreg_q[TOTAL-2:0], 1'b0};
                        if (bit_q == LAST_BIT) begin
                            state_q <= ST_IDLE;
                        end else begin
                            bit_q <= bit_q + 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o     = (state_q != ST_IDLE);
    assign frame_o    = (state_q == ST_FRAME);
    assign ser_clk_o  = (state_q == ST_SHIFT) && high_phase_i;
    assign ser_data_o = (state_q == ST_SHIFT) && shreg_q[TOTAL-1];

    AST_NO_CLK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        frame_o |-> !ser_clk_o); // R3
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!ser_clk_o && !ser_data_o && !frame_o)); // R6
    AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_SHIFT) && ($past(state_q) == ST_SHIFT) && !$fell(ser_clk_o))
        |-> $stable(ser_data_o)); // R6
    AST_START_FRAMES: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> frame_o); // R2
    AST_ONE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({frame_o, (state_q == ST_SHIFT)})); // R9

endmodule

// File: rtl/frame_serializer.sv
// Module: frame_serializer (top)
// Serializes six parallel sample words into a framed, gated three-wire port.
// Assumes: CLK_DIV is even and at least 2. smp_valid is a single-cycle strobe.
module frame_serializer #(
    parameter int WORD_W    = 16,
    parameter int NUM_WORDS = 6,
    parameter int CLK_DIV   = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        smp_valid,
    input  logic [NUM_WORDS*WORD_W-1:0] smp_data,
    output logic                        ser_clk,
    output logic                        frame_out,
    output logic                        ser_data,
    output logic                        busy,
    output logic                        overrun
);

    localparam int BUS_W = NUM_WORDS * WORD_W;

    logic             accept;
    logic [BUS_W-1:0] held;
    logic             period_end;
    logic             high_phase;

    fs_sample_hold #(.BUS_W(BUS_W)) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_valid_i (smp_valid),
        .smp_data_i  (smp_data),
        .busy_i      (busy),
        .accept_o    (accept),
        .held_o      (held),
        .overrun_o   (overrun)
    );

    fs_tick_gen #(.DIV(CLK_DIV)) u_tick (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_i        (busy),
        .period_end_o (period_end),
        .high_phase_o (high_phase)
    );

    fs_shift_engine #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_shift (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (accept),
        .period_end_i (period_end),
        .high_phase_i (high_phase),
        .held_i       (held),
        .ser_clk_o    (ser_clk),
        .frame_o      (frame_out),
        .ser_data_o   (ser_data),
        .busy_o       (busy)
    );

endmodule

// File: tb/frame_serializer_tb_top.sv
// Bench: drives whole frames and compares every output in every cycle with
// values computed from the cycle number k since the accepting edge.
module frame_serializer_tb_top;

    localparam int W    = 16;
    localparam int N    = 6;
    localparam int DIV  = 4;
    localparam int HALF = DIV / 2;
    localparam int BITS = W * N;
    localparam int ENDK = DIV + BITS * DIV;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            smp_valid = 1'b0;
    logic [BITS-1:0] smp_data = '0;
    logic            ser_clk, frame_out, ser_data, busy, overrun;

    int n_checks = 0;
    int n_fails  = 0;
    bit ovr_exp  = 1'b0;

    always #2.5 clk = ~clk;

    frame_serializer #(.WORD_W(W), .NUM_WORDS(N), .CLK_DIV(DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .ser_clk(ser_clk), .frame_out(frame_out), .ser_data(ser_data),
        .busy(busy), .overrun(overrun)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic chk_vec(input string req, input string what,
                           input logic [BITS-1:0] act, input logic [BITS-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [W-1:0] pat(input int p, input int k);
        case (p)
            0: pat = 16'h0000;
            1: pat = 16'hFFFF;
            2: pat = k[0] ? 16'h5555 : 16'hAAAA;
            3: pat = 16'h0001 << (k * 3);
            4: pat = 16'h8000 >> (k * 2);
            default: pat = W'((p * 40503 + k * 9973 + 17) & 16'hFFFF);
        endcase
    endfunction

    // Sends one frame from a falling edge. inj >= 0 places an extra strobe at cycle k = inj.
    task automatic run_frame(input logic [BITS-1:0] w, input int inj, input string tag);
        logic [BITS-1:0] cap = '0;
        int  nrise = 0;
        bit  prev_s = 1'b0;
        smp_valid = 1'b1;
        smp_data  = w;
        @(negedge clk);
        smp_valid = 1'b0;
        smp_data  = ~w;                       // R7: bus changes after capture
        for (int k = 0; k <= ENDK; k++) begin
            int ef, es, ed, eb;
            if (k < DIV) begin
                ef = 1; es = 0; ed = 0; eb = 1;
            end else if (k < ENDK) begin
                int j = k - DIV;
                int b = j / DIV;
                int c = j % DIV;
                ef = 0; eb = 1;
                es = (c >= HALF) ? 1 : 0;
                ed = int'(w[(b / W) * W + (W - 1) - (b % W)]);
            end else begin
                ef = 0; es = 0; ed = 0; eb = 0;
            end
            chk("R2", {tag, " frame_out"}, int'(frame_out), ef);
            chk(ef ? "R3" : "R4", {tag, " ser_clk"}, int'(ser_clk), es);
            chk("R6", {tag, " ser_data"}, int'(ser_data), ed);
            chk("R9", {tag, " busy"}, int'(busy), eb);
            chk("R8", {tag, " overrun"}, int'(overrun), int'(ovr_exp));
            if (ser_clk && !prev_s) begin
                cap = {cap[BITS-2:0], ser_data};
                nrise++;
            end
            prev_s = ser_clk;
            if (k == ENDK) break;
            if (k == inj) begin
                smp_valid = 1'b1;
                smp_data  = w ^ {BITS{1'b1}};
            end
            @(negedge clk);
            if (k == inj) begin
                smp_valid = 1'b0;
                ovr_exp   = 1'b1;            // R8: flag due one cycle after the strobe
            end
        end
        chk("R4", {tag, " rising serial edges"}, nrise, BITS);
        begin
            logic [BITS-1:0] exp_stream;
            for (int k = 0; k < N; k++) exp_stream[BITS-1-k*W -: W] = w[k*W +: W];
            chk_vec("R5", {tag, " word stream"}, cap, exp_stream);
        end
    endtask

    task automatic idle_cycles(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk("R8", {tag, " no stray frame busy"}, int'(busy), 0);
            chk("R3", {tag, " idle ser_clk"}, int'(ser_clk), 0);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        logic [BITS-1:0] w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1", "reset busy", int'(busy), 0);
        chk("R1", "reset ser_clk", int'(ser_clk), 0);
        chk("R1", "reset frame_out", int'(frame_out), 0);
        chk("R1", "reset ser_data", int'(ser_data), 0);
        chk("R1", "reset overrun", int'(overrun), 0);
        @(negedge clk);

        // Pattern sweep, back to back (R9: accepted on the first idle cycle).
        for (int p = 0; p < 8; p++) begin
            for (int k = 0; k < N; k++) w[k*W +: W] = pat(p, k);
            run_frame(w, -1, $sformatf("pat%0d", p));
        end

        // Strobes while busy: mid-frame and on the last busy cycle (R8).
        for (int k = 0; k < N; k++) w[k*W +: W] = pat(6, k);
        run_frame(w, 150, "ovr_mid");
        smp_data = '0;
        run_frame(~w, ENDK - 1, "ovr_last");
        idle_cycles(3 * DIV, "after_ovr");

        // Reset mid-frame (R1).
        smp_valid = 1'b1;
        smp_data  = w;
        @(negedge clk);
        smp_valid = 1'b0;
        repeat (200) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "midframe reset busy", int'(busy), 0);
        chk("R1", "midframe reset ser_clk", int'(ser_clk), 0);
        chk("R1", "midframe reset frame_out", int'(frame_out), 0);
        chk("R1", "midframe reset ser_data", int'(ser_data), 0);
        chk("R1", "midframe reset overrun", int'(overrun), 0);
        ovr_exp = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        idle_cycles(2, "after_reset");
        for (int k = 0; k < N; k++) w[k*W +: W] = pat(7, k);
        run_frame(w, -1, "post_reset");

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule